// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the address stream for a single DMA channel. A start pulse captures a base address, an inner element count with a signed inner step, an outer row count with a signed outer step, an element size, and mode bits. The block then offers one address at a time on a valid/ready port. After each accepted address it moves by the inner step. At the end of a row it applies the outer step in place of the inner step and reloads the inner count. Because the outer step can be smaller than the inner step, or negative, a channel can walk interleaved data and separate it into its streams.

When the final element of a buffer is accepted, the block does one of two things. In linear mode it goes idle. In autobuffer mode it reloads the base address and both counts and starts the next pass on its own. It raises a one-cycle completion pulse in both cases. Optionally it also raises a pulse at each row boundary, which signals a fractional buffer. While the channel runs, the current address and the remaining counts are visible at the ports. The data mover and the descriptor fetch sit outside this block.

Top module: `dma2d_agen`

## Requirements
- R1: During and directly after reset, addr_valid_o, busy_o, row_irq_o and done_irq_o are 0.
- R2: A start_i pulse while idle captures the configuration. In the next cycle busy_o and addr_valid_o are 1 and addr_o equals cfg_base_i.
- R3: When an address that is not the last of its row is accepted (valid and ready), the next address is the current one plus the inner step times the element size. While ready is low, addr_o holds its value and valid stays high.
- R4: When the last address of a row that is not the final row is accepted, the next address is the current one plus the outer step times the element size. The inner count reloads and the outer count drops by one. Both steps are signed 16-bit values.
- R5: cfg_size_i selects the element size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 4 bytes.
- R6: A count of 0, inner or outer, stands for 65536 elements.
- R7: With cfg_two_d_i = 0, cfg_ycnt_i and cfg_ystep_i are ignored. The buffer is a single row and cur_ycnt_o reads 1.
- R8: In linear mode (cfg_auto_i = 0), accepting the final address drops busy_o and addr_valid_o in the next cycle, and done_irq_o is 1 for that cycle.
- R9: In autobuffer mode (cfg_auto_i = 1), accepting the final address reloads the base address and both counts. The block stays busy and pulses done_irq_o once per pass.
- R10: When cfg_row_irq_i was set at start, row_irq_o pulses for one cycle after each accepted row end that is not the final row. When it was clear, row_irq_o stays 0. row_irq_o and done_irq_o are never 1 together.
- R11: While busy, cur_xcnt_o shows the elements left in the current row and cur_ycnt_o the rows left, each counting the current element or row.
- R12: start_i while busy_o is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures configuration when idle |
| cfg_base_i | input | AW | Start address |
| cfg_xcnt_i | input | 16 | Inner element count (0 means 65536) |
| cfg_xstep_i | input | 16 | Signed inner step in elements |
| cfg_ycnt_i | input | 16 | Outer row count (0 means 65536) |
| cfg_ystep_i | input | 16 | Signed outer step in elements |
| cfg_size_i | input | 2 | Element size code |
| cfg_two_d_i | input | 1 | 1 selects two-dimensional mode |
| cfg_auto_i | input | 1 | 1 selects autobuffer reload |
| cfg_row_irq_i | input | 1 | Enables the row completion pulse |
| addr_valid_o | output | 1 | Address offered |
| addr_ready_i | input | 1 | Address accepted when valid |
| addr_o | output | AW | Current address |
| busy_o | output | 1 | Channel running |
| cur_xcnt_o | output | 17 | Elements left in current row |
| cur_ycnt_o | output | 17 | Rows left in buffer |
| row_irq_o | output | 1 | Row completion pulse |
| done_irq_o | output | 1 | Buffer completion pulse |

## Verification
The hardest case to reach is the zero-count encoding. The count wraps to 65536 only after tens of thousands of accepted addresses. The stimulus therefore runs one 1-D buffer with a zero inner count and one 2-D buffer with a zero outer count, both with ready held high, so that each finishes in about 65536 cycles. A second awkward case is a start pulse that arrives while a job is running. The bench sends one mid-buffer with a different configuration and expects the address sequence to go on unchanged. Autobuffer runs, which never stop, are ended with a reset after several passes.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned REM_W  = CNT_W + 1;

  typedef struct packed {
    logic             two_d;
    logic             auto_rld;
    logic             row_en;
    logic [1:0]       size;
    logic [CNT_W-1:0] xcnt;
    logic [CNT_W-1:0] ycnt;
    logic [CNT_W-1:0] xstep;
    logic [CNT_W-1:0] ystep;
  } chan_cfg_t;

  // zero encodes the full range
  function automatic logic [REM_W-1:0] expand_cnt(logic [CNT_W-1:0] c);
    return {(c == '0), c};
  endfunction

  function automatic logic [1:0] size_shift(logic [1:0] s);
    return (s == 2'd3) ? 2'd2 : s;
  endfunction
endpackage

// File: rtl/dma2d_cfg_regs.sv
module dma2d_cfg_regs
  import dma2d_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  chan_cfg_t     cfg_i,
  output logic [AW-1:0] base_o,
  output chan_cfg_t     cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      cfg_o  <= '0;
    end else if (load_i) begin
      base_o <= base_i;
      cfg_o  <= cfg_i;
    end
  end
endmodule

// File: rtl/dma2d_cnt.sv
module dma2d_cnt #(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (dec_i)  cnt_o <= cnt_o - W'(1);
  end

  assign last_o = (cnt_o == W'(1));
endmodule

// File: rtl/dma2d_addr_step.sv
module dma2d_addr_step #(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          adv_i,
  input  logic [SW-1:0] step_i,
  input  logic [1:0]    shift_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned EXT_W = AW - SW;

  logic [AW-1:0] step_ext;
  logic [AW-1:0] offset;

  assign step_ext = {{EXT_W{step_i[SW-1]}}, step_i};
  assign offset   = step_ext << shift_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_val_i;
    else if (adv_i)  addr_o <= addr_o + offset;
  end
endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen
  import dma2d_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [15:0]   cfg_xcnt_i,
  input  logic [15:0]   cfg_xstep_i,
  input  logic [15:0]   cfg_ycnt_i,
  input  logic [15:0]   cfg_ystep_i,
  input  logic [1:0]    cfg_size_i,
  input  logic          cfg_two_d_i,
  input  logic          cfg_auto_i,
  input  logic          cfg_row_irq_i,
  output logic          addr_valid_o,
  input  logic          addr_ready_i,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic [16:0]   cur_xcnt_o,
  output logic [16:0]   cur_ycnt_o,
  output logic          row_irq_o,
  output logic          done_irq_o
);
  chan_cfg_t     cfg_in, cfg_q;
  logic [AW-1:0] base_q;
  logic          busy_q, row_q, done_q;
  logic          start_ok, fire, x_last, y_last, end_row, end_buf, rld;
  logic [REM_W-1:0] x_load_val, y_load_val, y_in_val, y_q_val;

  assign cfg_in = '{two_d: cfg_two_d_i, auto_rld: cfg_auto_i, row_en: cfg_row_irq_i,
                    size: cfg_size_i, xcnt: cfg_xcnt_i, ycnt: cfg_ycnt_i,
                    xstep: cfg_xstep_i, ystep: cfg_ystep_i};

  assign start_ok = start_i & ~busy_q;
  assign fire     = busy_q & addr_ready_i;
  assign end_row  = fire & x_last;
  assign end_buf  = end_row & y_last;
  assign rld      = end_buf & cfg_q.auto_rld;

  dma2d_cfg_regs #(.AW(AW)) i_cfg (
    .clk_i, .rst_ni, .load_i(start_ok), .base_i(cfg_base_i), .cfg_i(cfg_in),
    .base_o(base_q), .cfg_o(cfg_q)
  );

  assign y_in_val   = cfg_two_d_i ? expand_cnt(cfg_ycnt_i) : REM_W'(1);
  assign y_q_val    = cfg_q.two_d ? expand_cnt(cfg_q.ycnt) : REM_W'(1);
  assign x_load_val = start_ok ? expand_cnt(cfg_xcnt_i) : expand_cnt(cfg_q.xcnt);
  assign y_load_val = start_ok ? y_in_val : y_q_val;

  dma2d_cnt #(.W(REM_W)) i_xcnt (
    .clk_i, .rst_ni, .load_i(start_ok | end_row), .load_val_i(x_load_val),
    .dec_i(fire), .cnt_o(cur_xcnt_o), .last_o(x_last)
  );

  dma2d_cnt #(.W(REM_W)) i_ycnt (
    .clk_i, .rst_ni, .load_i(start_ok | rld), .load_val_i(y_load_val),
    .dec_i(end_row & ~y_last), .cnt_o(cur_ycnt_o), .last_o(y_last)
  );

  dma2d_addr_step #(.AW(AW), .SW(CNT_W)) i_addr (
    .clk_i, .rst_ni,
    .load_i(start_ok | rld),
    .load_val_i(start_ok ? cfg_base_i : base_q),
    .adv_i(fire & ~end_buf),
    .step_i(x_last ? cfg_q.ystep : cfg_q.xstep),
    .shift_i(size_shift(cfg_q.size)),
    .addr_o(addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      row_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (start_ok)                            busy_q <= 1'b1;
      else if (end_buf && !cfg_q.auto_rld)     busy_q <= 1'b0;
      row_q  <= end_row & ~y_last & cfg_q.row_en;
      done_q <= end_buf;
    end
  end

  assign busy_o       = busy_q;
  assign addr_valid_o = busy_q;
  assign row_irq_o    = row_q;
  assign done_irq_o   = done_q;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && !addr_ready_i) |=> (addr_valid_o && $stable(addr_o)));

  assert_no_zero_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cur_xcnt_o != '0 && cur_ycnt_o != '0));

  assert_one_row_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cfg_q.two_d) |-> (cur_ycnt_o == REM_W'(1)));

  assert_linear_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_irq_o && !cfg_q.auto_rld) |-> !busy_o);

  assert_auto_runs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_irq_o && cfg_q.auto_rld) |-> (busy_o && addr_o == base_q));

  assert_irq_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(row_irq_o && done_irq_o));

  assert_row_enable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_irq_o |-> cfg_q.row_en);

  assert_start_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !addr_ready_i) |=> $stable(addr_o));
endmodule

// File: tb/test_dma2d_agen.sv
module test_dma2d_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] xcnt = '0, xstep = '0, ycnt = '0, ystep = '0;
  logic [1:0]  size = '0;
  logic        two_d = 1'b0, auto_rld = 1'b0, row_en = 1'b0;
  logic        ready = 1'b0;
  logic        valid, busy, row_irq, done_irq;
  logic [31:0] addr;
  logic [16:0] cur_x, cur_y;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma2d_agen #(.AW(32)) i_dma2d_agen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_base_i(base),
    .cfg_xcnt_i(xcnt), .cfg_xstep_i(xstep), .cfg_ycnt_i(ycnt), .cfg_ystep_i(ystep),
    .cfg_size_i(size), .cfg_two_d_i(two_d), .cfg_auto_i(auto_rld),
    .cfg_row_irq_i(row_en), .addr_valid_o(valid), .addr_ready_i(ready),
    .addr_o(addr), .busy_o(busy), .cur_xcnt_o(cur_x), .cur_ycnt_o(cur_y),
    .row_irq_o(row_irq), .done_irq_o(done_irq)
  );

  // behavioural reference
  bit          m_busy, m_row, m_done;
  logic [31:0] m_addr, m_base;
  int          m_x, m_y, m_xn, m_yn, m_xs, m_ys, m_sz;
  bit          m_auto, m_ren;

  function automatic int cnt_of(logic [15:0] c);
    return (c == 0) ? 65536 : int'(c);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_row = 0; m_done = 0; m_addr = 0; m_x = 0; m_y = 0;
    end else begin
      m_row = 0; m_done = 0;
      if (start && !m_busy) begin
        m_busy = 1; m_base = base; m_addr = base; m_auto = auto_rld; m_ren = row_en;
        m_xn = cnt_of(xcnt); m_yn = two_d ? cnt_of(ycnt) : 1;
        m_xs = int'($signed(xstep)); m_ys = int'($signed(ystep));
        m_sz = (size == 0) ? 1 : (size == 1) ? 2 : 4;
        m_x = m_xn; m_y = m_yn;
      end else if (m_busy && ready) begin
        if (m_x == 1) begin
          if (m_y == 1) begin
            m_done = 1;
            if (m_auto) begin m_addr = m_base; m_x = m_xn; m_y = m_yn; end
            else m_busy = 0;
          end else begin
            m_row = m_ren; m_y = m_y - 1; m_x = m_xn;
            m_addr = m_addr + 32'(m_ys * m_sz);
          end
        end else begin
          m_x = m_x - 1;
          m_addr = m_addr + 32'(m_xs * m_sz);
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      check(busy == m_busy && valid == m_busy, "R8", "busy/valid", {busy, valid}, {m_busy, m_busy});
      if (m_busy) begin
        check(addr == m_addr, "R3/R4", "addr", addr, m_addr);
        check(int'(cur_x) == m_x && int'(cur_y) == m_y, "R11", "counts",
              {cur_x, cur_y}, {17'(m_x), 17'(m_y)});
      end
      check(row_irq == m_row, "R10", "row_irq", row_irq, m_row);
      check(done_irq == m_done, "R8/R9", "done_irq", done_irq, m_done);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic launch(logic [31:0] b, logic [15:0] xc, logic [15:0] xs, logic [15:0] yc,
                        logic [15:0] ys, logic [1:0] sz, bit td, bit au, bit re);
    @(negedge clk);
    base = b; xcnt = xc; xstep = xs; ycnt = yc; ystep = ys; size = sz;
    two_d = td; auto_rld = au; row_en = re; start = 1'b1; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    // R2: base offered one cycle after start
    check(valid && addr == b, "R2", "first addr", addr, b);
  endtask

  task automatic run(int mode, int limit);
    for (int i = 0; i < limit; i++) begin
      ready = (mode == 0) ? 1'b1 : 1'($urandom % 2);
      @(negedge clk);
      if (!m_busy) break;
    end
    ready = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!valid && !busy && !row_irq && !done_irq, "R1", "reset outputs",
          {valid, busy, row_irq, done_irq}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!valid && !busy && !row_irq && !done_irq, "R1", "reset outputs",
          {valid, busy, row_irq, done_irq}, 0);
    rst_n = 1'b1;

    // R7: 1-D, outer fields ignored; R5 size 2 bytes
    launch(32'h1000, 16'd5, 16'd1, 16'd3, 16'd9, 2'd1, 1'b0, 1'b0, 1'b1);
    check(cur_y == 17'd1, "R7", "1-D rows", cur_y, 1);
    ready = 1'b1; @(negedge clk); ready = 1'b0;
    // R12: start while busy with other settings
    start = 1'b1; base = 32'h9999; xcnt = 16'd2; two_d = 1'b1;
    @(negedge clk); start = 1'b0;
    check(addr == 32'h1002, "R12", "addr after ignored start", addr, 32'h1002);
    run(1, 200);

    // R4: interleave with negative outer step, byte size, row irq
    launch(32'h200, 16'd3, 16'd4, 16'd4, 16'hFFF9, 2'd0, 1'b1, 1'b0, 1'b1);
    run(1, 200);

    // R5: word sizes 2 and 3, negative inner step
    launch(32'h8000, 16'd2, 16'hFFFF, 16'd2, 16'd3, 2'd2, 1'b1, 1'b0, 1'b0);
    run(0, 50);
    launch(32'h8000, 16'd2, 16'hFFFF, 16'd2, 16'd3, 2'd3, 1'b1, 1'b0, 1'b1);
    run(1, 50);

    // R9: autobuffer with row pulses, then without
    launch(32'h4000, 16'd2, 16'd1, 16'd3, 16'd5, 2'd1, 1'b1, 1'b1, 1'b1);
    run(1, 60);
    check(busy, "R9", "still busy in autobuffer", busy, 1);
    do_reset();
    launch(32'h4400, 16'd3, 16'd2, 16'd2, 16'hFFFE, 2'd2, 1'b1, 1'b1, 1'b0);
    run(0, 40);
    check(busy, "R9", "still busy in autobuffer", busy, 1);
    do_reset();

    // R6: zero inner count in 1-D, zero outer count in 2-D
    launch(32'h0, 16'd0, 16'd1, 16'd0, 16'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    check(cur_x == 17'h10000, "R6", "zero inner count", cur_x, 17'h10000);
    run(0, 70000);
    check(!busy, "R6", "64K 1-D finished", busy, 0);
    launch(32'h100, 16'd1, 16'd0, 16'd0, 16'd1, 2'd0, 1'b1, 1'b0, 1'b0);
    check(cur_y == 17'h10000, "R6", "zero outer count", cur_y, 17'h10000);
    run(0, 70000);
    check(!busy, "R6", "64K rows finished", busy, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule